// File: doc/BRIEF.md
# Overhead Byte Persistence Filter

This block sits behind a receive framer and decides which received overhead values the host may see. Three fields are filtered. The first is a two-byte protection switching word. The second is a one-byte synchronization status code. The third is a one-byte path signal label. Each field has its own register, and that register follows the line only once a new value has arrived unchanged on enough consecutive frames. This keeps single-frame corruption out of the host view.

The framer pulses `frameStrobe` once per frame while the three received values are valid on their inputs. The protection word and the synchronization status both need three matching frames. The signal label needs either three or five matching frames, selected by the host. Each time a register takes a new value, it sets a sticky event bit. The host clears that bit by pulsing the matching clear line.

Top module: `ohb_persist_filter`

## Requirements
- R1: After reset, all three filtered registers and all three event bits read zero.
- R2: The protection register takes a new 16-bit value after it has been received on 3 consecutive strobed frames. The new value is visible in the cycle after the third strobe.
- R3: The two protection bytes are matched as one 16-bit word. A change in either byte starts the persistence count again for the whole word.
- R4: The synchronization status register takes a new value after 3 consecutive identical strobed frames.
- R5: The signal label register needs 3 identical frames when `labelLongSel` is 0, and 5 identical frames when it is 1.
- R6: A received value that differs from the previous strobed frame sets that field's match count back to one. The frames received before the change do not count toward the new value.
- R7: When the persisted value already equals the register contents, the register is not written and no event is raised.
- R8: Input values present while `frameStrobe` is low have no effect on the registers, the event bits or the persistence counts.
- R9: The event bits are ordered bit 0 = protection, bit 1 = synchronization status, bit 2 = signal label. An event bit goes to 1 when its register updates and stays at 1 until the matching `evtClear` bit is pulsed. If a clear and an update of the same field fall in the same cycle, the bit stays at 1.
- R10: A value that keeps persisting beyond its threshold causes only one update and one event. After the host clears the event, further identical frames do not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse per frame; received values are valid while high |
| protWordIn | input | 16 | Received protection switching word |
| syncStatusIn | input | 8 | Received synchronization status byte |
| sigLabelIn | input | 8 | Received path signal label byte |
| labelLongSel | input | 1 | Signal label persistence: 0 = 3 frames, 1 = 5 frames |
| evtClear | input | 3 | Per-field event clear pulses (host read) |
| protWordReg | output | 16 | Filtered protection word |
| syncStatusReg | output | 8 | Filtered synchronization status |
| sigLabelReg | output | 8 | Filtered signal label |
| evtFlags | output | 3 | Sticky per-field change events |

## Verification
Two things can fall in the same cycle for one field: the host clearing an event bit, and a frame that completes a persistence run and sets that same bit. The bench provokes this by pulsing the protection clear together with the third matching strobe of a new word. It then expects the bit still to read 1 on the following cycle. A plain clear with no update is checked separately and must bring the bit to 0. Several fields updating on the same strobe, each with its own event bit, are also covered.

// File: rtl/ohbf_pkg.sv
package ohbf_pkg;
  localparam int FIELD_N = 3;
  localparam int F_PROT  = 0;
  localparam int F_SYNC  = 1;
  localparam int F_LABEL = 2;

  // datapath -> control: comparison results for the current inputs
  typedef struct packed {
    logic [FIELD_N-1:0] sameAsLast;
    logic [FIELD_N-1:0] diffFromReg;
  } cmp_t;

  // control -> datapath: strobes
  typedef struct packed {
    logic               capture;
    logic [FIELD_N-1:0] load;
  } strobe_t;
endpackage

// File: rtl/ohbf_ctrl.sv
module ohbf_ctrl
  import ohbf_pkg::*;
#(
  parameter int PROT_DEPTH  = 3,
  parameter int SYNC_DEPTH  = 3,
  parameter int LABEL_SHORT = 3,
  parameter int LABEL_LONG  = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameStrobe,
  input  logic    labelLongSel,
  input  cmp_t    cmp,
  output strobe_t ctl
);
  localparam int MAX_A = (PROT_DEPTH > SYNC_DEPTH) ? PROT_DEPTH : SYNC_DEPTH;
  localparam int MAX_B = (LABEL_SHORT > LABEL_LONG) ? LABEL_SHORT : LABEL_LONG;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_D + 1);

  logic [FIELD_N-1:0] loadVec;

  for (genvar i = 0; i < FIELD_N; i++) begin : g_field
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] nextCnt;
    logic             same;

    if (i == F_LABEL) begin : g_thrLabel
      assign thr = labelLongSel ? CNT_W'(LABEL_LONG) : CNT_W'(LABEL_SHORT);
    end else if (i == F_SYNC) begin : g_thrSync
      assign thr = CNT_W'(SYNC_DEPTH);
    end else begin : g_thrProt
      assign thr = CNT_W'(PROT_DEPTH);
    end

    always_comb begin
      same = cmp.sameAsLast[i] && (cnt != '0);
      if (!same)          nextCnt = CNT_W'(1);
      else if (cnt < thr) nextCnt = cnt + CNT_W'(1);
      else                nextCnt = thr;   // saturate
    end

    always_ff @(posedge clk) begin
      if (!rstN)            cnt <= '0;
      else if (frameStrobe) cnt <= nextCnt;
    end

    assign loadVec[i] = frameStrobe && (nextCnt >= thr) && cmp.diffFromReg[i];
  end

  assign ctl = '{capture: frameStrobe, load: loadVec};
endmodule

// File: rtl/ohbf_datapath.sv
module ohbf_datapath
  import ohbf_pkg::*;
#(
  parameter int PROT_W  = 16,
  parameter int SYNC_W  = 8,
  parameter int LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PROT_W-1:0]  protWordIn,
  input  logic [SYNC_W-1:0]  syncStatusIn,
  input  logic [LABEL_W-1:0] sigLabelIn,
  input  logic [FIELD_N-1:0] evtClear,
  input  strobe_t            ctl,
  output cmp_t               cmp,
  output logic [PROT_W-1:0]  protWordReg,
  output logic [SYNC_W-1:0]  syncStatusReg,
  output logic [LABEL_W-1:0] sigLabelReg,
  output logic [FIELD_N-1:0] evtFlags
);
  logic [PROT_W-1:0]  lastProt;
  logic [SYNC_W-1:0]  lastSync;
  logic [LABEL_W-1:0] lastLabel;

  always_comb begin
    cmp.sameAsLast[F_PROT]   = (protWordIn   == lastProt);
    cmp.sameAsLast[F_SYNC]   = (syncStatusIn == lastSync);
    cmp.sameAsLast[F_LABEL]  = (sigLabelIn   == lastLabel);
    cmp.diffFromReg[F_PROT]  = (protWordIn   != protWordReg);
    cmp.diffFromReg[F_SYNC]  = (syncStatusIn != syncStatusReg);
    cmp.diffFromReg[F_LABEL] = (sigLabelIn   != sigLabelReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastProt  <= '0;
      lastSync  <= '0;
      lastLabel <= '0;
    end else if (ctl.capture) begin
      lastProt  <= protWordIn;
      lastSync  <= syncStatusIn;
      lastLabel <= sigLabelIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protWordReg   <= '0;
      syncStatusReg <= '0;
      sigLabelReg   <= '0;
    end else begin
      if (ctl.load[F_PROT])  protWordReg   <= protWordIn;
      if (ctl.load[F_SYNC])  syncStatusReg <= syncStatusIn;
      if (ctl.load[F_LABEL]) sigLabelReg   <= sigLabelIn;
    end
  end

  // set has priority over a coincident clear
  always_ff @(posedge clk) begin
    if (!rstN) evtFlags <= '0;
    else       evtFlags <= (evtFlags & ~evtClear) | ctl.load;
  end
endmodule

// File: rtl/ohb_persist_filter.sv
module ohb_persist_filter
  import ohbf_pkg::*;
#(
  parameter int PROT_W      = 16,
  parameter int SYNC_W      = 8,
  parameter int LABEL_W     = 8,
  parameter int PROT_DEPTH  = 3,
  parameter int SYNC_DEPTH  = 3,
  parameter int LABEL_SHORT = 3,
  parameter int LABEL_LONG  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStrobe,
  input  logic [PROT_W-1:0]  protWordIn,
  input  logic [SYNC_W-1:0]  syncStatusIn,
  input  logic [LABEL_W-1:0] sigLabelIn,
  input  logic               labelLongSel,
  input  logic [2:0]         evtClear,
  output logic [PROT_W-1:0]  protWordReg,
  output logic [SYNC_W-1:0]  syncStatusReg,
  output logic [LABEL_W-1:0] sigLabelReg,
  output logic [2:0]         evtFlags
);
  cmp_t    cmp;
  strobe_t ctl;

  ohbf_ctrl #(
    .PROT_DEPTH (PROT_DEPTH),
    .SYNC_DEPTH (SYNC_DEPTH),
    .LABEL_SHORT(LABEL_SHORT),
    .LABEL_LONG (LABEL_LONG)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .frameStrobe (frameStrobe),
    .labelLongSel(labelLongSel),
    .cmp         (cmp),
    .ctl         (ctl)
  );

  ohbf_datapath #(
    .PROT_W (PROT_W),
    .SYNC_W (SYNC_W),
    .LABEL_W(LABEL_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .protWordIn   (protWordIn),
    .syncStatusIn (syncStatusIn),
    .sigLabelIn   (sigLabelIn),
    .evtClear     (evtClear),
    .ctl          (ctl),
    .cmp          (cmp),
    .protWordReg  (protWordReg),
    .syncStatusReg(syncStatusReg),
    .sigLabelReg  (sigLabelReg),
    .evtFlags     (evtFlags)
  );
endmodule

// File: rtl/ohbf_checker.sv
module ohbf_checker #(
  parameter int PROT_W  = 16,
  parameter int SYNC_W  = 8,
  parameter int LABEL_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStrobe,
  input logic [PROT_W-1:0]  protWordIn,
  input logic [SYNC_W-1:0]  syncStatusIn,
  input logic [LABEL_W-1:0] sigLabelIn,
  input logic [2:0]         evtClear,
  input logic [PROT_W-1:0]  protWordReg,
  input logic [SYNC_W-1:0]  syncStatusReg,
  input logic [LABEL_W-1:0] sigLabelReg,
  input logic [2:0]         evtFlags
);
  assert_reg_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> ($stable(protWordReg) && $stable(syncStatusReg) && $stable(sigLabelReg)));

  assert_prot_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(protWordReg) |-> ($past(frameStrobe) && protWordReg == $past(protWordIn)));

  assert_sync_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncStatusReg) |-> ($past(frameStrobe) && syncStatusReg == $past(syncStatusIn)));

  assert_label_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sigLabelReg) |-> ($past(frameStrobe) && sigLabelReg == $past(sigLabelIn)));

  assert_evt_on_update_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(protWordReg) || !$stable(syncStatusReg) || !$stable(sigLabelReg)) |->
      ((!$stable(protWordReg)  -> evtFlags[0]) &&
       (!$stable(syncStatusReg) -> evtFlags[1]) &&
       (!$stable(sigLabelReg)   -> evtFlags[2])));

  assert_evt_clear_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(evtFlags[0]) |-> $past(evtClear[0]));
endmodule

bind ohb_persist_filter ohbf_checker #(
  .PROT_W (PROT_W),
  .SYNC_W (SYNC_W),
  .LABEL_W(LABEL_W)
) chk_i (.*);

// File: tb/ohb_persist_filter_tb.sv
module ohb_persist_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameStrobe;
  logic [15:0] protWordIn;
  logic [7:0]  syncStatusIn;
  logic [7:0]  sigLabelIn;
  logic        labelLongSel;
  logic [2:0]  evtClear;
  logic [15:0] protWordReg;
  logic [7:0]  syncStatusReg;
  logic [7:0]  sigLabelReg;
  logic [2:0]  evtFlags;

  always #10 clk = ~clk;   // 50 MHz

  ohb_persist_filter dut_i (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe),
    .protWordIn(protWordIn), .syncStatusIn(syncStatusIn), .sigLabelIn(sigLabelIn),
    .labelLongSel(labelLongSel), .evtClear(evtClear),
    .protWordReg(protWordReg), .syncStatusReg(syncStatusReg),
    .sigLabelReg(sigLabelReg), .evtFlags(evtFlags)
  );

  typedef struct {
    logic [15:0] prot;
    logic [7:0]  sync;
    logic [7:0]  label;
    logic [2:0]  flags;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  // reference model built from the requirements
  logic [15:0] mLast [3];
  logic [15:0] mReg  [3];
  int          mCnt  [3];
  logic [2:0]  mFlag;

  function automatic void modelField(int i, logic [15:0] v, int thr);
    if (mCnt[i] != 0 && v == mLast[i]) mCnt[i] = (mCnt[i] < thr) ? mCnt[i] + 1 : thr;
    else                               mCnt[i] = 1;
    mLast[i] = v;
    if (mCnt[i] >= thr && v != mReg[i]) begin
      mReg[i]  = v;
      mFlag[i] = 1'b1;
    end
  endfunction

  task automatic pushExp(string tag);
    exp_t e;
    e.prot = mReg[0]; e.sync = mReg[1][7:0]; e.label = mReg[2][7:0];
    e.flags = mFlag; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendFrame(logic [15:0] p, logic [7:0] s, logic [7:0] l,
                           logic [2:0] clr, string tag);
    @(negedge clk);
    protWordIn = p; syncStatusIn = s; sigLabelIn = l;
    evtClear = clr; frameStrobe = 1'b1;
    mFlag = mFlag & ~clr;
    modelField(0, p, 3);
    modelField(1, {8'h00, s}, 3);
    modelField(2, {8'h00, l}, labelLongSel ? 5 : 3);
    @(negedge clk);
    frameStrobe = 1'b0; evtClear = 3'b000;
    pushExp(tag);
    @(negedge clk);
  endtask

  task automatic hostClear(logic [2:0] clr, string tag);
    @(negedge clk);
    evtClear = clr;
    mFlag = mFlag & ~clr;
    @(negedge clk);
    evtClear = 3'b000;
    pushExp(tag);
  endtask

  // monitor: pops expected items and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (protWordReg !== e.prot || syncStatusReg !== e.sync ||
            sigLabelReg !== e.label || evtFlags !== e.flags) begin
          errors++;
          $display("FAIL %s: got prot=%h sync=%h label=%h evt=%b, expected prot=%h sync=%h label=%h evt=%b",
                   e.tag, protWordReg, syncStatusReg, sigLabelReg, evtFlags,
                   e.prot, e.sync, e.label, e.flags);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameStrobe = 1'b0; protWordIn = '0; syncStatusIn = '0;
    sigLabelIn = '0; labelLongSel = 1'b0; evtClear = '0;
    for (int i = 0; i < 3; i++) begin mLast[i] = '0; mReg[i] = '0; mCnt[i] = 0; end
    mFlag = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pushExp("R1 reset state");

    // R2: new protection word after three frames (R7: zero fields stay quiet)
    sendFrame(16'hA15C, 8'h00, 8'h00, 3'b000, "R2 frame1");
    sendFrame(16'hA15C, 8'h00, 8'h00, 3'b000, "R2 frame2");
    sendFrame(16'hA15C, 8'h00, 8'h00, 3'b000, "R2 frame3 update");
    hostClear(3'b001, "R9 clear prot event");

    // R3: one byte flips in the middle of a run
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 new word 1");
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 new word 2");
    sendFrame(16'h3C02, 8'h00, 8'h00, 3'b000, "R3 low byte flip");
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 restart 1");
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 restart 2");
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 restart 3 update");
    sendFrame(16'h4C01, 8'h00, 8'h00, 3'b000, "R3 high byte 1");
    sendFrame(16'h4C01, 8'h00, 8'h00, 3'b000, "R3 high byte 2");
    sendFrame(16'h3C01, 8'h00, 8'h00, 3'b000, "R3 back to old");
    hostClear(3'b001, "R9 clear prot event again");

    // R4 and R6: sync status with an interruption
    sendFrame(16'h3C01, 8'h0F, 8'h00, 3'b000, "R4 sync 1");
    sendFrame(16'h3C01, 8'h0F, 8'h00, 3'b000, "R4 sync 2");
    sendFrame(16'h3C01, 8'h0F, 8'h00, 3'b000, "R4 sync 3 update");
    sendFrame(16'h3C01, 8'h02, 8'h00, 3'b000, "R6 candidate 1");
    sendFrame(16'h3C01, 8'h02, 8'h00, 3'b000, "R6 candidate 2");
    sendFrame(16'h3C01, 8'h0B, 8'h00, 3'b000, "R6 interruption");
    sendFrame(16'h3C01, 8'h02, 8'h00, 3'b000, "R6 recount 1");
    sendFrame(16'h3C01, 8'h02, 8'h00, 3'b000, "R6 recount 2");
    sendFrame(16'h3C01, 8'h02, 8'h00, 3'b000, "R6 recount 3 update");
    hostClear(3'b010, "R9 clear sync event");

    // R5: label with short then long persistence
    sendFrame(16'h3C01, 8'h02, 8'h13, 3'b000, "R5 short 1");
    sendFrame(16'h3C01, 8'h02, 8'h13, 3'b000, "R5 short 2");
    sendFrame(16'h3C01, 8'h02, 8'h13, 3'b000, "R5 short 3 update");
    hostClear(3'b100, "R9 clear label event");
    labelLongSel = 1'b1;
    for (int k = 1; k <= 5; k++)
      sendFrame(16'h3C01, 8'h02, 8'h1B, 3'b000, $sformatf("R5 long %0d", k));

    // R10: persisting beyond threshold, event cleared, not raised again
    sendFrame(16'h3C01, 8'h02, 8'h1B, 3'b000, "R10 extra 1");
    hostClear(3'b100, "R10 clear");
    for (int k = 2; k <= 4; k++)
      sendFrame(16'h3C01, 8'h02, 8'h1B, 3'b000, $sformatf("R10 extra %0d", k));

    // R7: value equal to register persists again after a blip
    sendFrame(16'h0777, 8'h02, 8'h1B, 3'b000, "R7 blip");
    for (int k = 1; k <= 3; k++)
      sendFrame(16'h3C01, 8'h02, 8'h1B, 3'b000, $sformatf("R7 same value %0d", k));

    // R8: input noise with no strobe
    sendFrame(16'h5A5A, 8'h04, 8'h1B, 3'b000, "R8 pre 1");
    sendFrame(16'h5A5A, 8'h04, 8'h1B, 3'b000, "R8 pre 2");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      protWordIn = 16'h1111 * k[15:0]; syncStatusIn = 8'h30 + k[7:0]; sigLabelIn = 8'hE0 + k[7:0];
    end
    @(negedge clk);
    pushExp("R8 idle noise ignored");
    sendFrame(16'h5A5A, 8'h04, 8'h1B, 3'b000, "R8 run continues update");

    // R9: clear and update of the same field in one cycle; also multi-field update
    labelLongSel = 1'b0;
    sendFrame(16'hBEEF, 8'h07, 8'h2A, 3'b000, "R9 dual 1");
    sendFrame(16'hBEEF, 8'h07, 8'h2A, 3'b000, "R9 dual 2");
    sendFrame(16'hBEEF, 8'h07, 8'h2A, 3'b001, "R9 set wins over clear");
    hostClear(3'b111, "R9 clear all");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule